// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Registers

This block is a configuration window reached through two byte-wide I/O addresses on a simple bus: an index port and a data port. After reset the window is closed. While it is closed, every write to the index port is checked against a four-byte unlock key, and data-port accesses do nothing. When the key has been written in order, the window opens. The index port then selects a register and the data port reads or writes that register. Writing the exit code to a fixed index closes the window again.

Inside the window, one register holds a logical device selector, and three read-only registers give a 16-bit chip identity and a revision. These values are set by parameters. A small block of device registers is visible only while the selector holds the GPIO device number, and it maps onto an inferable RAM. Read data appears on `io_rdata` one cycle after the read strobe and stays there until the next read of a port. `cfg_active` shows whether the window is open.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, `cfg_active` is 0 and `io_rdata` is 0xFF.
- R2: Writing 0x87, 0x01, 0x55 and 0x55 in that order to the index port (0x2E) while closed opens the window. `cfg_active` goes high on the clock edge that takes the last key byte.
- R3: A wrong byte during key matching restarts the match. If the wrong byte is 0x87, it counts as the first byte of a new attempt.
- R4: While closed, reads of either port return 0xFF, and writes to the data port (0x2F) change no register.
- R5: While open, a write to the index port selects the register for later data accesses, and a read of the index port returns the selected index.
- R6: Index 0x07 is the logical device selector. It resets to 0x00 and can be read and written through the data port.
- R7: Index 0x20 reads the high byte of the chip ID (default 0x5A17), index 0x21 reads the low byte, and index 0x22 reads the revision with bits 7:4 forced to 0 (default revision parameter 0xA3 reads 0x03).
- R8: Data-port writes to indexes 0x20, 0x21 and 0x22 have no effect.
- R9: Indexes 0x30 to 0x3F reach 16 device registers only while the selector is 0x07. With any other selector they read 0x00 and ignore writes. Unmapped indexes read 0x00.
- R10: While open, writing 0x02 to the data port when the index is 0x02 closes the window. Any other value at index 0x02, or 0x02 at any other index, leaves it open.
- R11: Read data appears on `io_rdata` the cycle after a read strobe and holds until the next port read.
- R12: Reads and writes to addresses other than 0x2E and 0x2F change neither the registers nor `io_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after `io_rd` |
| cfg_active | output | 1 | High while the configuration window is open |

## Verification
Two states are hard to reach from the ports. The first is a key attempt that breaks partway through. The stimulus sends a sequence that fails on its last byte and then one that repeats the first key byte, so the overlap rule decides whether the window opens. The second is the proof that writes made while closed were dropped. A register has no visible value while the window is closed, so the bench sets the selector, closes the window, writes to the data port, then reopens the window and reads the selector back. Device-register isolation uses the same approach: the bench switches the selector away, writes, switches back and reads.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int KEY_LEN = 4;
  // Unlock key, first byte in the top byte
  localparam logic [8*KEY_LEN-1:0] UNLOCK_KEY = 32'h87_01_55_55;
  localparam logic [7:0] EXIT_IDX = 8'h02;
  localparam logic [7:0] EXIT_VAL = 8'h02;
  localparam logic [7:0] LDN_IDX  = 8'h07;
  localparam logic [7:0] IDH_IDX  = 8'h20;
  localparam logic [7:0] IDL_IDX  = 8'h21;
  localparam logic [7:0] REV_IDX  = 8'h22;
  localparam logic [7:0] IDLE_RD  = 8'hFF;

  typedef enum logic {SRC_FIX, SRC_RAM} rd_src_e;
endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       key_hit
);
  localparam int SW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

  logic [7:0]    exp_byte [KEY_LEN];
  logic [SW-1:0] step_q;
  logic          match;

  for (genvar k = 0; k < KEY_LEN; k++) begin : g_key
    assign exp_byte[k] = UNLOCK_KEY[8*(KEY_LEN-1-k) +: 8];
  end

  assign match   = (key_byte == exp_byte[step_q]);
  assign key_hit = key_wr && match && (step_q == SW'(KEY_LEN-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
    end else if (key_wr) begin
      if (match) begin
        step_q <= (step_q == SW'(KEY_LEN-1)) ? '0 : step_q + 1'b1;
      end else begin
        step_q <= (key_byte == exp_byte[0]) ? SW'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/sio_bank_ram.sv
module sio_bank_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/sio_rd_decode.sv
module sio_rd_decode
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h5A17,
  parameter logic [7:0]  CHIP_REV = 8'hA3
) (
  input  logic       open_q,
  input  logic       rd_idx,
  input  logic [7:0] index_q,
  input  logic [7:0] ldn_q,
  output logic [7:0] fix_val
);
  always_comb begin
    if (!open_q) begin
      fix_val = IDLE_RD;
    end else if (rd_idx) begin
      fix_val = index_q;
    end else begin
      unique case (index_q)
        LDN_IDX: fix_val = ldn_q;
        IDH_IDX: fix_val = CHIP_ID[15:8];
        IDL_IDX: fix_val = CHIP_ID[7:0];
        REV_IDX: fix_val = {4'h0, CHIP_REV[3:0]};
        default: fix_val = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] IDX_ADDR   = 16'h002E,
  parameter logic [15:0] DAT_ADDR   = 16'h002F,
  parameter logic [15:0] CHIP_ID    = 16'h5A17,
  parameter logic [7:0]  CHIP_REV   = 8'hA3,
  parameter logic [7:0]  GPIO_LDN   = 8'h07,
  parameter logic [7:0]  BANK_BASE  = 8'h30,
  parameter int          BANK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_active
);
  localparam int         AW        = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam logic [7:0] BANK_LAST = BANK_BASE + 8'(BANK_DEPTH - 1);

  logic       open_q;
  logic [7:0] index_q;
  logic [7:0] ldn_q;
  rd_src_e    src_q;
  logic [7:0] fix_q;
  logic [7:0] fix_val;
  logic [7:0] ram_rd;
  logic       idx_sel, dat_sel;
  logic       wr_idx, wr_dat, rd_idx, rd_dat;
  logic       in_bank, key_hit;
  logic [AW-1:0] bank_addr;

  assign idx_sel = (io_addr == ADDR_W'(IDX_ADDR));
  assign dat_sel = (io_addr == ADDR_W'(DAT_ADDR));
  assign wr_idx  = io_wr && idx_sel;
  assign wr_dat  = io_wr && dat_sel;
  assign rd_idx  = io_rd && idx_sel;
  assign rd_dat  = io_rd && dat_sel;

  assign in_bank   = (index_q >= BANK_BASE) && (index_q <= BANK_LAST) &&
                     (ldn_q == GPIO_LDN);
  assign bank_addr = AW'(index_q - BANK_BASE);

  sio_key_seq u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_idx && !open_q),
    .key_byte (io_wdata),
    .key_hit  (key_hit)
  );

  sio_bank_ram #(.DW(8), .DEPTH(BANK_DEPTH)) u_ram (
    .clk   (clk),
    .we    (open_q && wr_dat && in_bank),
    .waddr (bank_addr),
    .wdata (io_wdata),
    .re    (open_q && rd_dat && in_bank),
    .raddr (bank_addr),
    .rdata (ram_rd)
  );

  sio_rd_decode #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_dec (
    .open_q  (open_q),
    .rd_idx  (rd_idx),
    .index_q (index_q),
    .ldn_q   (ldn_q),
    .fix_val (fix_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else if (!open_q) begin
      if (key_hit) open_q <= 1'b1;
    end else begin
      if (wr_idx) index_q <= io_wdata;
      if (wr_dat && index_q == LDN_IDX) ldn_q <= io_wdata;
      if (wr_dat && index_q == EXIT_IDX && io_wdata == EXIT_VAL) open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_FIX;
      fix_q <= IDLE_RD;
    end else if (rd_idx || rd_dat) begin
      src_q <= (open_q && rd_dat && in_bank) ? SRC_RAM : SRC_FIX;
      fix_q <= fix_val;
    end
  end

  assign io_rdata   = (src_q == SRC_RAM) ? ram_rd : fix_q;
  assign cfg_active = open_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IDX_ADDR = 16'h002E,
  parameter logic [15:0] DAT_ADDR = 16'h002F
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cfg_active,
  input logic [7:0]        index_q,
  input logic [7:0]        ldn_q
);
  // R2: the window opens only right after a final key byte on the index port
  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_active) |-> $past(io_wr && io_addr == ADDR_W'(IDX_ADDR) && io_wdata == 8'h55));

  // R4: a closed window answers data-port reads with 0xFF
  assert_locked_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_active && io_rd && io_addr == ADDR_W'(DAT_ADDR)) |=> io_rdata == IDLE_RD);

  // R6: the selector moves only on an open data-port write
  assert_ldn_guard_R6: assert property (@(posedge clk) disable iff (rst)
    !(cfg_active && io_wr && io_addr == ADDR_W'(DAT_ADDR)) |=> $stable(ldn_q));

  // R7: revision reads have a zero upper nibble
  assert_rev_nibble_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_active && io_rd && io_addr == ADDR_W'(DAT_ADDR) && index_q == REV_IDX)
    |=> io_rdata[7:4] == 4'h0);

  // R10: the exit code closes the window
  assert_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_active && io_wr && io_addr == ADDR_W'(DAT_ADDR) &&
     index_q == EXIT_IDX && io_wdata == EXIT_VAL) |=> !cfg_active);

  // R11: without a read strobe the read data holds
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_active(cfg_active),
  .index_q(index_q), .ldn_q(ldn_q)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cfg_active;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_active(cfg_active)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // Driver: pushes the expected byte and tag, then strobes the read
  task automatic rd(logic [15:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h55);
  endtask

  // Monitor: compares the result one cycle after each port read
  initial begin
    forever begin
      @(posedge clk);
      if (io_rd && (io_addr == IP || io_addr == DP)) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check8("scoreboard underflow", io_rdata, 8'hxx);
        end else begin
          check8(tag_q.pop_front(), io_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check8("R1 cfg_active after reset", {7'b0, cfg_active}, 8'h00);
    check8("R1 io_rdata after reset", io_rdata, 8'hFF);

    // Closed window
    rd(DP, 8'hFF, "R4 locked data read");
    rd(IP, 8'hFF, "R4 locked index read");

    // Broken key attempts
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h01);
    check8("R3 broken key stays closed", {7'b0, cfg_active}, 8'h00);
    wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h55);
    check8("R3 tail of key does not open", {7'b0, cfg_active}, 8'h00);
    wr(IP, 8'h87); wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55);
    check8("R2 open only after last byte", {7'b0, cfg_active}, 8'h00);
    wr(IP, 8'h55);
    check8("R3 repeated first byte restarts, R2 opens", {7'b0, cfg_active}, 8'h01);

    // Index and identity
    wr(IP, 8'h22);
    rd(IP, 8'h22, "R5 index readback");
    rd(DP, 8'h03, "R7 revision");
    wr(IP, 8'h20); rd(DP, 8'h5A, "R7 id high");
    wr(IP, 8'h21); rd(DP, 8'h17, "R7 id low");
    wr(DP, 8'hCC); rd(DP, 8'h17, "R8 id low read-only");
    wr(IP, 8'h22); wr(DP, 8'h00); rd(DP, 8'h03, "R8 revision read-only");

    // Selector
    wr(IP, 8'h07); rd(DP, 8'h00, "R6 selector reset value");
    wr(DP, 8'h07); rd(DP, 8'h07, "R6 selector write");

    // Device registers
    wr(IP, 8'h30); wr(DP, 8'hA5);
    wr(IP, 8'h3F); wr(DP, 8'h3C);
    rd(DP, 8'h3C, "R9 bank last entry");
    wr(IP, 8'h30); rd(DP, 8'hA5, "R9 bank first entry");
    wr(IP, 8'h40); rd(DP, 8'h00, "R9 unmapped index");
    wr(IP, 8'h07); wr(DP, 8'h05);
    wr(IP, 8'h30); rd(DP, 8'h00, "R9 other device reads zero");
    wr(DP, 8'hFF);
    wr(IP, 8'h07); wr(DP, 8'h07);
    wr(IP, 8'h30); rd(DP, 8'hA5, "R9 other device write ignored");

    // Foreign addresses and hold
    wr(IP, 8'h07);
    wr(16'h0070, 8'h11);
    rd(DP, 8'h07, "R12 foreign write ignored");
    @(negedge clk); io_addr = 16'h0070; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    @(negedge clk);
    check8("R12 foreign read leaves rdata", io_rdata, 8'h07);
    repeat (3) @(negedge clk);
    check8("R11 rdata holds", io_rdata, 8'h07);

    // Exit sequence
    wr(IP, 8'h02); wr(DP, 8'h01);
    check8("R10 wrong exit value keeps open", {7'b0, cfg_active}, 8'h01);
    wr(IP, 8'h05); wr(DP, 8'h02);
    check8("R10 exit value at other index keeps open", {7'b0, cfg_active}, 8'h01);
    wr(IP, 8'h02); wr(DP, 8'h02);
    check8("R10 exit closes", {7'b0, cfg_active}, 8'h00);
    rd(DP, 8'hFF, "R4 read after exit");

    // Closed-window writes dropped
    wr(DP, 8'h09);
    unlock();
    check8("R2 reopen", {7'b0, cfg_active}, 8'h01);
    wr(IP, 8'h07);
    rd(DP, 8'h07, "R4 closed write ignored");

    repeat (4) @(negedge clk);
    check8("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule